// File: doc/BRIEF.md
# Module clock gating controller

This block holds the clock-control state for a set of peripheral modules and a few clock domains. Software reaches it over a simple 32-bit register bus. Each module register carries a mode request. The block answers with a mode readback, an idle status and, on modules that have one, an optional functional-clock enable. Software writes a request and then polls the register until the status matches. A modelled handshake delay of `LAT` cycles keeps the status from changing at once.

Each clock-domain register holds a transition-control code. Its activity bits rise `LAT` cycles after a wakeup request and fall the same number of cycles after any other code. A separate register holds the functional-clock source select. Two reset registers complete the set: one holds a subsystem reset level, and the other fires a one-cycle warm-reset pulse. The enables, activity bits, source select and reset lines are driven out as plain levels for the clock and reset fabric.

The request channel takes valid/ready. `req_ready` stays high, so a request is accepted in every cycle that `req_valid` is high. A read returns its data one cycle after acceptance, marked by `rsp_valid`. The requester must take the response in that cycle, because the response channel has no back-pressure. The low two address bits are ignored. The word index selects a register: modules at words 0..N_MOD-1, domains from word 16, source select at word 20, subsystem reset at word 24, warm reset at word 28. N_MOD may be at most 16 and N_DOM at most 4.

Top module: `cg_ctrl`

## Requirements
- R1: Module register fields are the mode readback in bits 1:0 and the idle status in bits 17:16. Writing mode code 2 makes the readback 2, the idle status 0 and the module's `mod_en_o` bit 1. Writing code 0 or code 1 makes the readback 0, the idle status 3 and `mod_en_o` 0. After reset every module reads mode 0 with idle status 3.
- R2: Readback, idle status and `mod_en_o` change exactly `LAT` clock edges after the edge that accepts the write. Until then they keep their old values.
- R3: A module write whose bits 1:0 hold the reserved code 3 is ignored entirely, including bit 18.
- R4: On a module whose `OPT_MASK` bit is set, bit 18 is written together with the mode. It reads back in bit 18 and drives `mod_opt_o` after the same `LAT` delay. On other modules, bit 18 always reads 0.
- R5: A domain register stores bits 1:0 at once and reads them back. Writing code 2 sets the domain's activity bits (bit 4 interface, bit 5 timer, bit 6 serial, limited by `ACT_MASK`) `LAT` edges later. Any other code clears them after the same delay.
- R6: The source-select register (word 20, bits 1:0) takes code 0 for the external pin clock, 1 for the main oscillator and 2 for the 32 kHz clock. It drives `clk_sel_o` and reads back the code. Code 3 is ignored.
- R7: The subsystem-reset register (word 24) holds `sub_rst_o` in bit 1. It is 1 after reset and follows bit 1 of each write, so a read-modify-write clearing bit 1 releases it.
- R8: A write to word 28 with bit 1 set gives a one-cycle `warm_rst_o` pulse in the cycle after acceptance. That register reads as 0.
- R9: Reads of unmapped words return 0, and writes to them change no state.
- R10: `req_ready` is always 1. Each accepted read raises `rsp_valid` for one cycle with the data in the next cycle, reflecting state before that cycle's edge.
- R11: A new accepted write to a module or domain whose status change is still pending cancels it and restarts the `LAT` delay with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| mod_en_o | output | N_MOD | Per-module clock enable (mode readback is 2) |
| mod_opt_o | output | N_MOD | Per-module optional functional-clock enable |
| dom_act_o | output | 3*N_DOM | Activity bits, three per domain |
| clk_sel_o | output | 2 | Selected functional-clock source code |
| sub_rst_o | output | 1 | Subsystem reset level |
| warm_rst_o | output | 1 | Warm-reset pulse |

## Verification
Read data and `rsp_valid` are due one edge after the request, and the warm-reset pulse is also due one edge after its write. Source select and the reset level are due one edge after their write. Module status, the optional enable and the domain activity bits move on the `LAT`-th edge after the write. A cancelling rewrite restarts that count from the new write. The bench keeps a behavioural model that steps on the same edges and compares every output a quarter period after each rising edge, so a status that moves one cycle early or late is caught at once.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int WORD_DOM_BASE = 16;
  localparam int WORD_CLKSEL   = 20;
  localparam int WORD_PERRST   = 24;
  localparam int WORD_DEVRST   = 28;
  localparam int OPT_BIT       = 18;
  localparam int RST_BIT       = 1;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_OFF1 = 2'd1,
    MODE_ON   = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    IDLE_FUNC = 2'd0,
    IDLE_OFF  = 2'd3
  } idle_e;
endpackage

// File: rtl/cg_lag_unit.sv
// Holds a requested value and publishes it LAT edges after the load edge.
module cg_lag_unit #(
  parameter int W = 1,
  parameter int LAT = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic [W-1:0] cur
);
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

  logic [W-1:0]  tgt;
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt  <= RST_VAL;
      cur  <= RST_VAL;
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      tgt  <= value;
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        cur  <= tgt;
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cg_read_mux.sv
module cg_read_mux import cg_pkg::*; #(
  parameter int N_MOD = 4,
  parameter int N_DOM = 2,
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0]            word,
  input  logic [N_MOD-1:0][31:0]      mod_img,
  input  logic [N_DOM-1:0][31:0]      dom_img,
  input  logic [1:0]                  clk_sel,
  input  logic                        sub_rst,
  output logic [31:0]                 rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_MOD; i++)
      if (word == IDX_W'(i)) rdata = mod_img[i];
    for (int d = 0; d < N_DOM; d++)
      if (word == IDX_W'(WORD_DOM_BASE + d)) rdata = dom_img[d];
    if (word == IDX_W'(WORD_CLKSEL)) rdata = {30'd0, clk_sel};
    if (word == IDX_W'(WORD_PERRST)) rdata = {30'd0, sub_rst, 1'b0};
  end
endmodule

// File: rtl/cg_ctrl.sv
module cg_ctrl import cg_pkg::*; #(
  parameter int N_MOD = 4,
  parameter int N_DOM = 2,
  parameter int LAT = 8,
  parameter int ADDR_W = 8,
  parameter logic [N_MOD-1:0]   OPT_MASK = 4'b1100,
  parameter logic [3*N_DOM-1:0] ACT_MASK = 6'b111001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic [N_MOD-1:0]    mod_en_o,
  output logic [N_MOD-1:0]    mod_opt_o,
  output logic [3*N_DOM-1:0]  dom_act_o,
  output logic [1:0]          clk_sel_o,
  output logic                sub_rst_o,
  output logic                warm_rst_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic             wr_en, rd_en;
  logic [IDX_W-1:0] word;
  mode_e            wmode;
  logic [N_MOD-1:0][31:0] mod_img;
  logic [N_DOM-1:0][31:0] dom_img;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign req_ready   = 1'b1;
  assign wr_en       = req_valid & req_write;
  assign rd_en       = req_valid & ~req_write;
  assign word        = req_addr[ADDR_W-1:2];
  assign wmode       = mode_e'(req_wdata[1:0]);
  assign unused_bits = ^{req_wdata[31:19], req_wdata[17:2], req_addr[1:0]};

  // Per-module mode/optional-enable state with modelled handshake lag
  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    logic       load;
    logic [2:0] value, cur;
    idle_e      idle;

    assign load  = wr_en && (word == IDX_W'(i)) && (wmode != MODE_RSVD);
    assign value = {OPT_MASK[i] & req_wdata[OPT_BIT],
                    (wmode == MODE_ON) ? MODE_ON : MODE_OFF};

    cg_lag_unit #(.W(3), .LAT(LAT), .RST_VAL(3'b000)) u_lag (
      .clk(clk), .rst_n(rst_n), .load(load), .value(value), .cur(cur));

    assign idle         = (mode_e'(cur[1:0]) == MODE_ON) ? IDLE_FUNC : IDLE_OFF;
    assign mod_en_o[i]  = (mode_e'(cur[1:0]) == MODE_ON);
    assign mod_opt_o[i] = cur[2];
    assign mod_img[i]   = {13'd0, cur[2], idle, 14'd0, cur[1:0]};
  end

  // Clock-domain transition control and lagged activity bits
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic       hit, act;
    logic [1:0] ctl;
    logic [2:0] act_bits;

    assign hit = wr_en && (word == IDX_W'(WORD_DOM_BASE + d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctl <= 2'd0;
      else if (hit) ctl <= req_wdata[1:0];
    end

    cg_lag_unit #(.W(1), .LAT(LAT), .RST_VAL(1'b0)) u_lag (
      .clk(clk), .rst_n(rst_n), .load(hit),
      .value(req_wdata[1:0] == 2'd2), .cur(act));

    assign act_bits           = {3{act}} & ACT_MASK[3*d +: 3];
    assign dom_act_o[3*d +: 3] = act_bits;
    assign dom_img[d]         = {25'd0, act_bits, 2'b00, ctl};
  end

  // Source select, reset controls and read response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_o  <= 2'd0;
      sub_rst_o  <= 1'b1;
      warm_rst_o <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (wr_en && word == IDX_W'(WORD_CLKSEL) && req_wdata[1:0] != 2'd3)
        clk_sel_o <= req_wdata[1:0];
      if (wr_en && word == IDX_W'(WORD_PERRST))
        sub_rst_o <= req_wdata[RST_BIT];
      warm_rst_o <= wr_en && word == IDX_W'(WORD_DEVRST) && req_wdata[RST_BIT];
      rsp_valid  <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end

  cg_read_mux #(.N_MOD(N_MOD), .N_DOM(N_DOM), .IDX_W(IDX_W)) u_rmux (
    .word(word), .mod_img(mod_img), .dom_img(dom_img),
    .clk_sel(clk_sel_o), .sub_rst(sub_rst_o), .rdata(rd_mux));
endmodule

// File: rtl/cg_ctrl_checker.sv
module cg_ctrl_checker import cg_pkg::*; #(
  parameter int N_MOD = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wr_bit1,
  input logic              rsp_valid,
  input logic [N_MOD-1:0]  mod_en_o,
  input logic [1:0]        clk_sel_o,
  input logic              sub_rst_o,
  input logic              warm_rst_o
);
  localparam int IDX_W = ADDR_W - 2;

  p_read_answered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_rsp_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_o != 2'd3);

  p_sub_rst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(sub_rst_o));

  p_warm_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |-> $past(req_valid && req_write && wr_bit1 &&
                         req_addr[ADDR_W-1:2] == IDX_W'(WORD_DEVRST)));

  for (genvar i = 0; i < N_MOD; i++) begin : g_chk
    p_lag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr[ADDR_W-1:2] == IDX_W'(i))
      |=> $stable(mod_en_o[i]));
  end
endmodule

bind cg_ctrl cg_ctrl_checker #(.N_MOD(N_MOD), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .wr_bit1(req_wdata[1]), .rsp_valid(rsp_valid),
  .mod_en_o(mod_en_o), .clk_sel_o(clk_sel_o), .sub_rst_o(sub_rst_o),
  .warm_rst_o(warm_rst_o));

// File: tb/cg_ctrl_bench.sv
module cg_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_MOD = 4;
  localparam int N_DOM = 2;
  localparam int LAT = 8;
  localparam int ADDR_W = 8;
  localparam logic [3:0] OPT_MASK = 4'b1100;
  localparam logic [5:0] ACT_MASK = 6'b111001;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, sub_rst_o, warm_rst_o;
  logic [31:0] rsp_rdata;
  logic [3:0] mod_en_o, mod_opt_o;
  logic [5:0] dom_act_o;
  logic [1:0] clk_sel_o;

  int vectors = 0, miscompares = 0;
  string cur_tag = "R1";
  bit done = 0;

  cg_ctrl #(.N_MOD(N_MOD), .N_DOM(N_DOM), .LAT(LAT), .ADDR_W(ADDR_W),
            .OPT_MASK(OPT_MASK), .ACT_MASK(ACT_MASK)) u_cg_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mod_en_o(mod_en_o),
    .mod_opt_o(mod_opt_o), .dom_act_o(dom_act_o), .clk_sel_o(clk_sel_o),
    .sub_rst_o(sub_rst_o), .warm_rst_o(warm_rst_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_mode[N_MOD], m_opt[N_MOD], m_tmode[N_MOD], m_topt[N_MOD], m_cnt[N_MOD], m_busy[N_MOD];
  int d_ctl[N_DOM], d_act[N_DOM], d_tact[N_DOM], d_cnt[N_DOM], d_busy[N_DOM];
  int e_sel = 0, e_sub = 1, e_warm = 0, e_rv = 0;
  logic [31:0] e_rd = 0;

  function automatic logic [31:0] image(int w);
    logic [31:0] r = 0;
    if (w < N_MOD) r = (m_opt[w] << 18) | ((m_mode[w] == 2 ? 0 : 3) << 16) | m_mode[w];
    else if (w >= 16 && w < 16 + N_DOM)
      r = ((d_act[w-16] ? ((ACT_MASK >> (3*(w-16))) & 7) : 0) << 4) | d_ctl[w-16];
    else if (w == 20) r = e_sel;
    else if (w == 24) r = e_sub << 1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_MOD; i++) begin
        m_mode[i] = 0; m_opt[i] = 0; m_busy[i] = 0; m_cnt[i] = 0; m_tmode[i] = 0; m_topt[i] = 0;
      end
      for (int d = 0; d < N_DOM; d++) begin
        d_ctl[d] = 0; d_act[d] = 0; d_busy[d] = 0; d_cnt[d] = 0; d_tact[d] = 0;
      end
      e_sel = 0; e_sub = 1; e_warm = 0; e_rv = 0; e_rd = 0;
    end else begin
      int w;
      bit wr;
      w = int'(req_addr[7:2]);
      wr = req_valid && req_write;
      e_rv = req_valid && !req_write;
      if (e_rv) e_rd = image(w);
      e_warm = (wr && w == 28 && req_wdata[1]) ? 1 : 0;
      for (int i = 0; i < N_MOD; i++) begin
        if (wr && w == i && req_wdata[1:0] != 2'd3) begin
          m_tmode[i] = (req_wdata[1:0] == 2'd2) ? 2 : 0;
          m_topt[i] = OPT_MASK[i] ? int'(req_wdata[18]) : 0;
          m_cnt[i] = LAT - 1; m_busy[i] = 1;
        end else if (m_busy[i] != 0) begin
          if (m_cnt[i] == 0) begin m_mode[i] = m_tmode[i]; m_opt[i] = m_topt[i]; m_busy[i] = 0; end
          else m_cnt[i]--;
        end
      end
      for (int d = 0; d < N_DOM; d++) begin
        if (wr && w == 16 + d) begin
          d_ctl[d] = int'(req_wdata[1:0]);
          d_tact[d] = (req_wdata[1:0] == 2'd2) ? 1 : 0;
          d_cnt[d] = LAT - 1; d_busy[d] = 1;
        end else if (d_busy[d] != 0) begin
          if (d_cnt[d] == 0) begin d_act[d] = d_tact[d]; d_busy[d] = 0; end
          else d_cnt[d]--;
        end
      end
      if (wr && w == 20 && req_wdata[1:0] != 2'd3) e_sel = int'(req_wdata[1:0]);
      if (wr && w == 24) e_sub = int'(req_wdata[1]);
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  // Compare every cycle, a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      logic [3:0] ee, eo;
      logic [5:0] ea;
      for (int i = 0; i < N_MOD; i++) begin
        ee[i] = (m_mode[i] == 2);
        eo[i] = (m_opt[i] != 0);
      end
      for (int d = 0; d < N_DOM; d++)
        ea[3*d +: 3] = d_act[d] ? ACT_MASK[3*d +: 3] : 3'b000;
      chk(32'(mod_en_o), 32'(ee), "mod_en_o");
      chk(32'(mod_opt_o), 32'(eo), "mod_opt_o");
      chk(32'(dom_act_o), 32'(ea), "dom_act_o");
      chk(32'(clk_sel_o), e_sel, "clk_sel_o");
      chk(32'(sub_rst_o), e_sub, "sub_rst_o");
      chk(32'(warm_rst_o), e_warm, "warm_rst_o");
      chk(32'(req_ready), 1, "req_ready (R10)");
      chk(32'(rsp_valid), e_rv, "rsp_valid (R10)");
      if (rsp_valid && e_rv != 0) chk(rsp_rdata, e_rd, "rsp_rdata");
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
  endtask
  task automatic rd(input int a);
    req_valid = 1; req_write = 0; req_addr = 8'(a); req_wdata = 0;
    @(negedge clk);
  endtask
  task automatic gap(input int n);
    req_valid = 0; req_write = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";   // reset state at the ports
    chk(32'(mod_en_o), 0, "reset mod_en_o");
    chk(32'(dom_act_o), 0, "reset dom_act_o (R5)");
    chk(32'(sub_rst_o), 1, "reset sub_rst_o (R7)");
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N_MOD; i++) rd(4*i);
    wr(0, 32'd2); gap(LAT + 1); rd(0);
    wr(0, 32'd1); gap(LAT + 1); rd(0);
    cur_tag = "R2";
    wr(4, 32'd2);
    for (int k = 0; k < LAT + 2; k++) rd(4);
    gap(2);
    cur_tag = "R3";
    wr(4, 32'h0004_0003); gap(LAT + 2); rd(4);
    cur_tag = "R4";
    wr(8, 32'h0004_0002); wr(0, 32'h0004_0002);
    gap(LAT + 1); rd(8); rd(0);
    wr(8, 32'h0000_0002); gap(LAT + 1); rd(8);
    cur_tag = "R5";
    wr(64, 32'd2); wr(68, 32'd2); rd(64); rd(68);
    gap(LAT); rd(64); rd(68);
    wr(68, 32'd1); gap(LAT + 1); rd(68);
    cur_tag = "R6";
    wr(80, 32'd1); rd(80); wr(80, 32'd2); rd(80);
    wr(80, 32'd3); rd(80); wr(80, 32'd0); rd(80);
    cur_tag = "R7";
    rd(96); wr(96, 32'h0); rd(96); wr(96, 32'h2); rd(96); wr(96, 32'h0);
    cur_tag = "R8";
    wr(112, 32'h2); gap(2); wr(112, 32'h1); rd(112); wr(112, 32'h2); wr(112, 32'h2); gap(2);
    cur_tag = "R9";
    wr(60, 32'hFFFF_FFFF); rd(60); wr(116, 32'hFFFF_FFFF); rd(116);
    wr(252, 32'h2); rd(252); rd(84); gap(LAT + 1);
    for (int i = 0; i < N_MOD; i++) rd(4*i);
    cur_tag = "R10";
    rd(0); rd(64); rd(80); rd(96); gap(1);
    cur_tag = "R11";
    wr(12, 32'd2); gap(3); wr(12, 32'd1); gap(LAT + 2); rd(12);
    wr(12, 32'h0004_0002); gap(LAT - 2); wr(12, 32'd0); gap(LAT + 1); rd(12);
    wr(64, 32'd2); gap(LAT - 1); wr(64, 32'd0); gap(LAT + 1); rd(64);
    gap(3);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule